// File: doc/BRIEF.md
# Byte-Oriented Register-File Execute Unit

This block executes two byte-wide register-file instructions for a small 8-bit core: a subtract that takes the working register W and a pending borrow from a data-memory byte, and an exchange of the two halves of a data-memory byte. A 16-bit instruction word carries the operation code, a destination select, an address-mode select and an 8-bit file address. Each instruction occupies one slot of four clock phases. The unit latches and decodes the word, reads the operand from a banked data memory through a plain address/data port, computes, and then commits the result to W or back to memory together with the status flags.

The data memory lives outside the block and is reached through a 12-bit address formed from a 4-bit bank and the file address. A direct mode maps the lower half of the file addresses to bank 0 and the upper half to bank 15. A banked mode takes the bank from an internal bank register. The surrounding core can set W, the bank register and the flags through a load slot. This stands in for the other instructions that would write them.

Top module: `rfx_exec_unit`

## Requirements
- R1: Opcode bits [15:10]=010110 subtracts W and the inverted carry from the operand byte, giving (f - W - (1 - C)) mod 256.
- R2: After a subtract, C (flags_out bit 0) is 1 exactly when no borrow leaves bit 7, and DC (bit 1) is 1 exactly when no borrow leaves bit 3.
- R3: After a subtract, Z (bit 2) is 1 when the result is zero, and N (bit 4) equals result bit 7.
- R4: After a subtract, OV (bit 3) is 1 when the signed difference f - W - borrow lies outside -128..127.
- R5: Opcode bits [15:10]=001110 exchanges bits 7:4 and 3:0 of the operand and leaves all five flags unchanged.
- R6: Instruction bit 9 selects the destination. With 0 the result goes to W and memory is not written. With 1 the result is written to the operand address and W is unchanged.
- R7: Instruction bit 8 selects the address mode. With 0 the address is {0x0, f} for f below 0x80 and {0xF, f} otherwise. With 1 it is {bank register, f}.
- R8: Any other opcode changes neither W, the flags nor memory.
- R9: The phase output steps 0,1,2,3 and wraps. The instruction is taken in phase 0. mem_we and every change of W and the flags occur only at the end of phase 3.
- R10: A synchronous reset sets the phase to 0 and clears W, the bank register and the flags.
- R11: With ld_en high in phase 0, the slot ignores instr and, at the end of phase 3, loads W, the bank register and the flags from ld_w, ld_bsr and ld_flags (bit order N, OV, Z, DC, C from bit 4 down).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 16 | Instruction word, sampled in phase 0 |
| ld_en | input | 1 | Turns the current slot into a state load |
| ld_w | input | 8 | W value for a load slot |
| ld_bsr | input | 4 | Bank register value for a load slot |
| ld_flags | input | 5 | Flag values for a load slot {N,OV,Z,DC,C} |
| mem_rdata | input | 8 | Data memory read data for mem_addr |
| phase | output | 2 | Current phase of the slot, 0 to 3 |
| w_out | output | 8 | Working register W |
| flags_out | output | 5 | Status flags {N,OV,Z,DC,C} |
| mem_addr | output | 12 | Data memory address {bank, f} |
| mem_we | output | 1 | Data memory write strobe |
| mem_wdata | output | 8 | Data memory write data |

## Verification
A phase counter that slips shows within one clock as a phase output that does not step by one. It also shows as a write strobe outside phase 3. A wrong latched destination or address mode appears at the end of the same slot, when the byte in memory at the expected address or W does not match. A corrupted carry does not show until the next subtract. That subtract's result is then off by one. For this reason the mixed random stream chains subtracts through the same flags over many slots.

// File: rtl/rfx_pkg.sv
package rfx_pkg;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        OP_NOP  = 2'd0,
        OP_SUBB = 2'd1,
        OP_SWAP = 2'd2,
        OP_LOAD = 2'd3
    } op_e;

    // bit 4 down to bit 0: N, OV, Z, DC, C
    typedef struct packed {
        logic n;
        logic ov;
        logic z;
        logic dc;
        logic c;
    } flags_t;

    localparam logic [5:0] OPC_SUBB = 6'b010110;
    localparam logic [5:0] OPC_SWAP = 6'b001110;

endpackage

// File: rtl/rfx_decode.sv
module rfx_decode
    import rfx_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned INSTR_W = DATA_W + 8
) (
    input  logic [INSTR_W-1:0] instr,
    output op_e                op,
    output logic               dst_f,
    output logic               banked,
    output logic [DATA_W-1:0]  faddr
);

    logic [5:0] opcode;

    always_comb begin
        opcode = instr[INSTR_W-1 -: 6];
        dst_f  = instr[DATA_W+1];
        banked = instr[DATA_W];
        faddr  = instr[DATA_W-1:0];
        unique case (opcode)
            OPC_SUBB: op = OP_SUBB;
            OPC_SWAP: op = OP_SWAP;
            default:  op = OP_NOP;
        endcase
    end

endmodule

// File: rtl/rfx_bank_addr.sv
module rfx_bank_addr #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned BANK_W = 4,
    localparam int unsigned ADDR_W = DATA_W + BANK_W
) (
    input  logic              banked,
    input  logic [BANK_W-1:0] bsr,
    input  logic [DATA_W-1:0] faddr,
    output logic [ADDR_W-1:0] addr
);

    logic [BANK_W-1:0] bank;

    always_comb begin
        if (banked) begin
            bank = bsr;
        end else begin
            bank = {BANK_W{faddr[DATA_W-1]}};
        end
        addr = {bank, faddr};
    end

endmodule

// File: rtl/rfx_alu.sv
module rfx_alu
    import rfx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] opnd,
    input  logic [DATA_W-1:0] w,
    input  flags_t            flags_in,
    output logic [DATA_W-1:0] res,
    output flags_t            flags_out
);

    localparam int unsigned HALF = DATA_W / 2;
    localparam int unsigned FW   = DATA_W + 1;
    localparam int unsigned LW   = HALF + 1;

    logic [DATA_W:0] full_sum;
    logic [HALF:0]   low_sum;

    always_comb begin
        full_sum  = {1'b0, opnd} + {1'b0, ~w} + FW'(flags_in.c);
        low_sum   = {1'b0, opnd[HALF-1:0]} + {1'b0, ~w[HALF-1:0]} + LW'(flags_in.c);
        res       = opnd;
        flags_out = flags_in;
        unique case (op)
            OP_SUBB: begin
                res          = full_sum[DATA_W-1:0];
                flags_out.c  = full_sum[DATA_W];
                flags_out.dc = low_sum[HALF];
                flags_out.z  = (full_sum[DATA_W-1:0] == '0);
                flags_out.n  = full_sum[DATA_W-1];
                flags_out.ov = (opnd[DATA_W-1] != w[DATA_W-1]) &&
                               (full_sum[DATA_W-1] != opnd[DATA_W-1]);
            end
            OP_SWAP: begin
                res = {opnd[HALF-1:0], opnd[DATA_W-1:HALF]};
            end
            default: begin
                res       = opnd;
                flags_out = flags_in;
            end
        endcase
    end

endmodule

// File: rtl/rfx_exec_unit.sv
module rfx_exec_unit
    import rfx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned BANK_W = 4,
    localparam int unsigned ADDR_W  = DATA_W + BANK_W,
    localparam int unsigned INSTR_W = DATA_W + 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] instr,
    input  logic               ld_en,
    input  logic [DATA_W-1:0]  ld_w,
    input  logic [BANK_W-1:0]  ld_bsr,
    input  logic [4:0]         ld_flags,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [1:0]         phase,
    output logic [DATA_W-1:0]  w_out,
    output logic [4:0]         flags_out,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_we,
    output logic [DATA_W-1:0]  mem_wdata
);

    typedef struct packed {
        phase_e            phase;
        op_e               op;
        logic              dst_f;
        logic              banked;
        logic [DATA_W-1:0] faddr;
        logic [BANK_W-1:0] bsr_new;
        logic [DATA_W-1:0] opnd;
        logic [DATA_W-1:0] res;
        flags_t            fl_new;
        logic [DATA_W-1:0] w;
        logic [BANK_W-1:0] bsr;
        flags_t            flags;
    } state_t;

    state_t s_q, s_d;

    op_e               dec_op;
    logic              dec_dst_f;
    logic              dec_banked;
    logic [DATA_W-1:0] dec_faddr;
    logic [DATA_W-1:0] alu_res;
    flags_t            alu_flags;

    rfx_decode #(.DATA_W(DATA_W), .INSTR_W(INSTR_W)) u_decode (
        .instr  (instr),
        .op     (dec_op),
        .dst_f  (dec_dst_f),
        .banked (dec_banked),
        .faddr  (dec_faddr)
    );

    rfx_bank_addr #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_bank (
        .banked (s_q.banked),
        .bsr    (s_q.bsr),
        .faddr  (s_q.faddr),
        .addr   (mem_addr)
    );

    rfx_alu #(.DATA_W(DATA_W)) u_alu (
        .op        (s_q.op),
        .opnd      (s_q.opnd),
        .w         (s_q.w),
        .flags_in  (s_q.flags),
        .res       (alu_res),
        .flags_out (alu_flags)
    );

    always_comb begin
        s_d       = s_q;
        s_d.phase = phase_e'(2'(s_q.phase + 2'd1));
        unique case (s_q.phase)
            PH_Q1: begin
                if (ld_en) begin
                    s_d.op      = OP_LOAD;
                    s_d.dst_f   = 1'b0;
                    s_d.banked  = 1'b0;
                    s_d.res     = ld_w;
                    s_d.fl_new  = flags_t'(ld_flags);
                    s_d.bsr_new = ld_bsr;
                end else begin
                    s_d.op     = dec_op;
                    s_d.dst_f  = dec_dst_f;
                    s_d.banked = dec_banked;
                    s_d.faddr  = dec_faddr;
                end
            end
            PH_Q2: begin
                s_d.opnd = mem_rdata;
            end
            PH_Q3: begin
                if (s_q.op != OP_LOAD) begin
                    s_d.res    = alu_res;
                    s_d.fl_new = alu_flags;
                end
            end
            PH_Q4: begin
                unique case (s_q.op)
                    OP_LOAD: begin
                        s_d.w     = s_q.res;
                        s_d.bsr   = s_q.bsr_new;
                        s_d.flags = s_q.fl_new;
                    end
                    OP_SUBB: begin
                        s_d.flags = s_q.fl_new;
                        if (!s_q.dst_f) s_d.w = s_q.res;
                    end
                    OP_SWAP: begin
                        if (!s_q.dst_f) s_d.w = s_q.res;
                    end
                    default: begin
                        s_d.w = s_q.w;
                    end
                endcase
            end
            default: begin
                s_d.phase = PH_Q1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase     = s_q.phase;
    assign w_out     = s_q.w;
    assign flags_out = s_q.flags;
    assign mem_wdata = s_q.res;
    assign mem_we    = (s_q.phase == PH_Q4) && s_q.dst_f &&
                       ((s_q.op == OP_SUBB) || (s_q.op == OP_SWAP));

endmodule

// File: rtl/rfx_exec_unit_chk.sv
module rfx_exec_unit_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned BANK_W = 4,
    localparam int unsigned ADDR_W = DATA_W + BANK_W
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        phase,
    input logic              mem_we,
    input logic [DATA_W-1:0] w_out,
    input logic [4:0]        flags_out,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              banked
);

    p_phase_step_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (phase == 2'($past(phase) + 2'd1)));

    p_write_in_q4_r9: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (phase == 2'd3));

    p_w_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (phase != 2'd3) |=> $stable(w_out));

    p_flags_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (phase != 2'd3) |=> $stable(flags_out));

    p_direct_map_r7: assert property (@(posedge clk) disable iff (rst)
        !banked |-> (mem_addr[ADDR_W-1:DATA_W] == {BANK_W{mem_addr[DATA_W-1]}}));

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> ((phase == 2'd0) && (w_out == '0) && (flags_out == '0)));

endmodule

bind rfx_exec_unit rfx_exec_unit_chk #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .mem_we    (mem_we),
    .w_out     (w_out),
    .flags_out (flags_out),
    .mem_addr  (mem_addr),
    .banked    (s_q.banked)
);

// File: tb/rfx_exec_unit_bench.sv
module rfx_exec_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr = '0;
    logic        ld_en = 1'b0;
    logic [7:0]  ld_w = '0;
    logic [3:0]  ld_bsr = '0;
    logic [4:0]  ld_flags = '0;
    logic [7:0]  mem_rdata;
    logic [1:0]  phase;
    logic [7:0]  w_out;
    logic [4:0]  flags_out;
    logic [11:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;

    logic [7:0] mem     [0:4095];
    logic [7:0] ref_mem [0:4095];
    logic [7:0] rw;
    logic [3:0] rbsr;
    logic [4:0] rfl;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rfx_exec_unit u_rfx_exec_unit (
        .clk       (clk),
        .rst       (rst),
        .instr     (instr),
        .ld_en     (ld_en),
        .ld_w      (ld_w),
        .ld_bsr    (ld_bsr),
        .ld_flags  (ld_flags),
        .mem_rdata (mem_rdata),
        .phase     (phase),
        .w_out     (w_out),
        .flags_out (flags_out),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata)
    );

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // returns {N,OV,Z,DC,C,result}
    function automatic logic [12:0] ref_sub(input logic [7:0] f, input logic [7:0] w, input logic c);
        int b, df, lo, sd;
        logic [7:0] r;
        b  = c ? 0 : 1;
        df = int'(f) - int'(w) - b;
        lo = int'(f[3:0]) - int'(w[3:0]) - b;
        sd = int'($signed(f)) - int'($signed(w)) - b;
        r  = df[7:0];
        return {r[7], (sd > 127) || (sd < -128), r == 8'h00, lo >= 0, df >= 0, r};
    endfunction

    function automatic logic [11:0] ref_addr(input logic a, input logic [7:0] f, input logic [3:0] bsr);
        if (a) return {bsr, f};
        return (f >= 8'h80) ? {4'hF, f} : {4'h0, f};
    endfunction

    task automatic poke(input logic [11:0] a, input logic [7:0] v);
        mem[a]     = v;
        ref_mem[a] = v;
    endtask

    // one four-phase slot; starts and ends at a falling edge with phase 0
    task automatic slot(input logic ld, input logic [7:0] lw, input logic [3:0] lb,
                        input logic [4:0] lf, input logic [15:0] ins);
        logic [11:0] a;
        logic [7:0]  opnd;
        logic [12:0] sr;
        string tag;
        chk("R9 phase at slot start", 16'(phase), 16'd0);
        ld_en = ld; ld_w = lw; ld_bsr = lb; ld_flags = lf; instr = ins;
        a    = ref_addr(ins[8], ins[7:0], rbsr);
        opnd = ref_mem[a];
        if (ld) begin
            tag = "R11 load"; rw = lw; rbsr = lb; rfl = lf;
        end else if (ins[15:10] == 6'b010110) begin
            tag = "R1/R2/R3/R4/R6/R7 subtract";
            sr  = ref_sub(opnd, rw, rfl[0]);
            rfl = sr[12:8];
            if (ins[9]) ref_mem[a] = sr[7:0]; else rw = sr[7:0];
        end else if (ins[15:10] == 6'b001110) begin
            tag = "R5/R6/R7 swap";
            if (ins[9]) ref_mem[a] = {opnd[3:0], opnd[7:4]}; else rw = {opnd[3:0], opnd[7:4]};
        end else begin
            tag = "R8 other opcode";
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        ld_en = 1'b0;
        chk({tag, " W"}, 16'(w_out), 16'(rw));
        chk({tag, " flags"}, 16'(flags_out), 16'(rfl));
        chk({tag, " memory"}, 16'(mem[a]), 16'(ref_mem[a]));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rw = '0; rbsr = '0; rfl = '0;
        chk("R10 phase after reset", 16'(phase), 16'd0);
        chk("R10 W after reset", 16'(w_out), 16'd0);
        chk("R10 flags after reset", 16'(flags_out), 16'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1357));
        for (int i = 0; i < 4096; i++) poke(12'(i), 8'($urandom));
        rw = '0; rbsr = '0; rfl = '0;
        @(negedge clk);
        do_reset();

        // stated subtract vectors
        poke(12'h019, 8'h19);
        slot(1'b1, 8'h0D, 4'h0, 5'b00001, 16'h0000);
        slot(1'b0, 8'h00, 4'h0, 5'b00000, 16'h5A19);
        chk("R1 0x19-0x0D result", 16'(mem[12'h019]), 16'h000C);
        chk("R2/R3 0x19-0x0D flags", 16'(flags_out), 16'b00001);

        poke(12'h01B, 8'h1B);
        slot(1'b1, 8'h1A, 4'h0, 5'b00000, 16'h0000);
        slot(1'b0, 8'h00, 4'h0, 5'b00000, 16'h5A1B);
        chk("R1 0x1B-0x1A-1 result", 16'(mem[12'h01B]), 16'h0000);
        chk("R2/R3 zero result flags", 16'(flags_out), 16'b00111);

        poke(12'h003, 8'h03);
        slot(1'b1, 8'h0E, 4'h0, 5'b00001, 16'h0000);
        slot(1'b0, 8'h00, 4'h0, 5'b00000, 16'h5803);
        chk("R6 result to W", 16'(w_out), 16'h00F5);
        chk("R6 memory untouched", 16'(mem[12'h003]), 16'h0003);
        chk("R2/R3 negative flags", 16'(flags_out), 16'b10000);

        // signed overflow
        poke(12'h020, 8'h80);
        slot(1'b1, 8'h01, 4'h0, 5'b00001, 16'h0000);
        slot(1'b0, 8'h00, 4'h0, 5'b00000, 16'h5820);
        chk("R4 overflow result", 16'(w_out), 16'h007F);
        chk("R4 overflow flags", 16'(flags_out), 16'b01001);

        // swap, flags left alone
        poke(12'h053, 8'h53);
        slot(1'b0, 8'h00, 4'h0, 5'b00000, 16'h3A53);
        chk("R5 swap 0x53", 16'(mem[12'h053]), 16'h0035);
        chk("R5 swap keeps flags", 16'(flags_out), 16'b01001);

        // direct mode upper half, then banked mode
        poke(12'hF80, 8'hA5);
        poke(12'h080, 8'h11);
        slot(1'b0, 8'h00, 4'h0, 5'b00000, 16'h3A80);
        chk("R7 direct high half to bank 15", 16'(mem[12'hF80]), 16'h005A);
        chk("R7 bank 0 copy untouched", 16'(mem[12'h080]), 16'h0011);
        poke(12'h580, 8'h3C);
        slot(1'b1, 8'h7F, 4'h5, 5'b01001, 16'h0000);
        slot(1'b0, 8'h00, 4'h0, 5'b00000, 16'h3B80);
        chk("R7 banked address", 16'(mem[12'h580]), 16'h00C3);
        chk("R7 bank 15 untouched", 16'(mem[12'hF80]), 16'h005A);

        // other opcode
        slot(1'b0, 8'h00, 4'h0, 5'b00000, 16'hFFFF);
        chk("R8 W kept", 16'(w_out), 16'h007F);
        chk("R8 flags kept", 16'(flags_out), 16'b01001);

        // mixed random stream
        for (int k = 0; k < 2000; k++) begin
            int r, sel;
            logic [15:0] ins;
            r   = int'($urandom % 16);
            sel = int'($urandom % 8);
            ins = 16'($urandom);
            if (sel < 4)      ins[15:10] = 6'b010110;
            else if (sel < 6) ins[15:10] = 6'b001110;
            if (r < 2) slot(1'b1, 8'($urandom), 4'($urandom), 5'($urandom), ins);
            else       slot(1'b0, 8'($urandom), 4'($urandom), 5'($urandom), ins);
        end

        // reset mid-run clears the bank register too
        slot(1'b1, 8'hAA, 4'h9, 5'b11111, 16'h0000);
        do_reset();
        poke(12'h010, 8'h96);
        poke(12'h910, 8'h12);
        slot(1'b0, 8'h00, 4'h0, 5'b00000, 16'h3B10);
        chk("R10 bank register cleared", 16'(mem[12'h010]), 16'h0069);
        chk("R10 old bank untouched", 16'(mem[12'h910]), 16'h0012);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule